// File: doc/BRIEF.md
# Registered Instruction Field Decoder

This block sits at the decode stage of a small 16-bit processor whose instructions are all one 16-bit word, with eight general registers. On every clock edge where the advance input is high, it splits the instruction word into fields and latches them. The latched fields are the destination register select, two source register selects, a five-bit ALU operation made from the opcode and a mode bit, a 16-bit immediate, and a flag that tells later stages whether a register is written back.

Every field sits at the same bit position in every instruction form, so most outputs are plain wiring into the output registers. The only logic that looks at the opcode is the write-back flag. The ALU, register file, memory and program counter logic are separate blocks that read these outputs.

Top module: `insn_field_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is zero on the next edge, `wb_en` included.
- R2: With `advance` high, `dst_sel` takes instruction bits [11:9], `srca_sel` takes bits [7:5] and `srcb_sel` takes bits [4:2], one clock after the edge. Any of the eight register numbers 0 to 7 can appear.
- R3: With `advance` high, `alu_op` becomes {insn[15:12], insn[8]}. The opcode is in bits 4:1 and the mode bit is in bit 0.
- R4: With `advance` high, `imm_word` becomes {insn[7:0], insn[7:0]}, meaning the low byte appears in both halves.
- R5: With `advance` high, `wb_en` becomes 0 for opcode 4'b0111 (store), 4'b1100 (jump) and 4'b1101 (conditional jump). It becomes 1 for the other thirteen codes, including the reserved codes 4'b1110 and 4'b1111.
- R6: With `advance` low and reset inactive, every output keeps its previous value, whatever `insn` holds.
- R7: The mode bit (insn[8]) and the spare bits [1:0] have no effect on `wb_en` or on the register selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| advance | input | 1 | Latches a new decode on this edge |
| insn | input | 16 | Instruction word |
| dst_sel | output | 3 | Destination register number |
| srca_sel | output | 3 | First source register number |
| srcb_sel | output | 3 | Second source register number |
| alu_op | output | 5 | Opcode followed by the mode bit |
| imm_word | output | 16 | 8-bit immediate copied into both bytes |
| wb_en | output | 1 | Register write-back enable |

## Verification
The bench runs all sixteen opcodes, each with the mode bit both clear and set. A design that keyed write-back off the wrong codes, or treated the reserved codes as non-writing, would show a wrong `wb_en` on exactly those patterns. Long stretches with `advance` low and `insn` changing every cycle would expose an output register enabled by the clock alone. Random words with distinct values in the two immediate bytes would catch a high byte taken from bits [15:8] instead of being replicated, as well as select fields shifted by one bit.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
    localparam int INSN_W = 16;
    localparam int OPC_W  = 4;
    localparam int REG_W  = 3;
    localparam int IMM_W  = 8;
    localparam int OP_W   = OPC_W + 1;
    localparam int IMMX_W = 2 * IMM_W;

    localparam int OPC_LSB  = 12;
    localparam int DST_LSB  = 9;
    localparam int MODE_BIT = 8;
    localparam int SRCA_LSB = 5;
    localparam int SRCB_LSB = 2;
    localparam int IMM_LSB  = 0;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD = 4'h0, OPC_SUB = 4'h1, OPC_OR  = 4'h2, OPC_XOR = 4'h3,
        OPC_AND = 4'h4, OPC_NOT = 4'h5, OPC_RD  = 4'h6, OPC_ST  = 4'h7,
        OPC_LDI = 4'h8, OPC_CMP = 4'h9, OPC_SHL = 4'hA, OPC_SHR = 4'hB,
        OPC_JMP = 4'hC, OPC_JEQ = 4'hD, OPC_RS0 = 4'hE, OPC_RS1 = 4'hF
    } opcode_e;

    typedef struct packed {
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  srca;
        logic [REG_W-1:0]  srcb;
        logic [OP_W-1:0]   op;
        logic [IMMX_W-1:0] imm;
        logic              wb;
    } dec_fields_t;
endpackage

// File: rtl/insn_field_split.sv
// insn_field_split: pure wiring that pulls the fixed-position fields out of
// an instruction word. Assumes every instruction form shares one layout.
module insn_field_split
    import insn_dec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic [OPC_W-1:0]  opc,
    output logic [REG_W-1:0]  dst,
    output logic [REG_W-1:0]  srca,
    output logic [REG_W-1:0]  srcb,
    output logic              mode,
    output logic [IMMX_W-1:0] imm_rep
);
    localparam int REPS = IMMX_W / IMM_W;

    assign opc  = insn[OPC_LSB  +: OPC_W];
    assign dst  = insn[DST_LSB  +: REG_W];
    assign srca = insn[SRCA_LSB +: REG_W];
    assign srcb = insn[SRCB_LSB +: REG_W];
    assign mode = insn[MODE_BIT];

    // Copy the immediate byte into every lane of the wide immediate.
    for (genvar g = 0; g < REPS; g++) begin : g_rep
        assign imm_rep[g*IMM_W +: IMM_W] = insn[IMM_LSB +: IMM_W];
    end
endmodule

// File: rtl/insn_wb_rule.sv
// insn_wb_rule: decides register write-back from the opcode alone.
// Assumes store and both jumps are the only non-writing codes.
module insn_wb_rule
    import insn_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output logic             wb
);
    // Clear write-back for opcodes that produce no register result.
    always_comb begin
        unique case (opcode_e'(opc))
            OPC_ST, OPC_JMP, OPC_JEQ: wb = 1'b0;
            default:                  wb = 1'b1;
        endcase
    end
endmodule

// File: rtl/insn_field_decoder.sv
// insn_field_decoder: registered decode stage. Latches the fields and the
// write-back flag when advance is high. Reset is synchronous, active low.
module insn_field_decoder
    import insn_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [INSN_W-1:0] insn,
    output logic [REG_W-1:0]  dst_sel,
    output logic [REG_W-1:0]  srca_sel,
    output logic [REG_W-1:0]  srcb_sel,
    output logic [OP_W-1:0]   alu_op,
    output logic [IMMX_W-1:0] imm_word,
    output logic              wb_en
);
    logic [OPC_W-1:0]  opc;
    logic              mode;
    dec_fields_t       nxt;
    dec_fields_t       q;

    insn_field_split u_split (
        .insn    (insn),
        .opc     (opc),
        .dst     (nxt.dst),
        .srca    (nxt.srca),
        .srcb    (nxt.srcb),
        .mode    (mode),
        .imm_rep (nxt.imm)
    );

    insn_wb_rule u_wb (
        .opc (opc),
        .wb  (nxt.wb)
    );

    assign nxt.op = {opc, mode};

    // Output register: clear on reset, load on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (advance) q <= nxt;
    end

    assign dst_sel  = q.dst;
    assign srca_sel = q.srca;
    assign srcb_sel = q.srcb;
    assign alu_op   = q.op;
    assign imm_word = q.imm;
    assign wb_en    = q.wb;
endmodule

// File: rtl/insn_field_decoder_chk.sv
// insn_field_decoder_chk: temporal checks on the decoder ports.
module insn_field_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        advance,
    input logic [15:0] insn,
    input logic [2:0]  dst_sel,
    input logic [2:0]  srca_sel,
    input logic [2:0]  srcb_sel,
    input logic [4:0]  alu_op,
    input logic [15:0] imm_word,
    input logic        wb_en
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (alu_op == 5'd0 && imm_word == 16'd0 && !wb_en && dst_sel == 3'd0));
    // R2
    sel_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (dst_sel == $past(insn[11:9]) && srca_sel == $past(insn[7:5])
                     && srcb_sel == $past(insn[4:2])));
    // R3
    op_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> alu_op == {$past(insn[15:12]), $past(insn[8])});
    // R4
    imm_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_word[15:8] == imm_word[7:0]);
    // R5
    wb_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && (insn[15:12] == 4'h7 || insn[15:12] == 4'hC || insn[15:12] == 4'hD))
        |=> !wb_en);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && $past(rst_n)) |=> ($stable(alu_op) && $stable(imm_word) && $stable(wb_en)
                          && $stable(dst_sel)));
endmodule

bind insn_field_decoder insn_field_decoder_chk u_chk (.*);

// File: tb/tb_insn_field_decoder.sv
module tb_insn_field_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance = 1'b0;
    logic [15:0] insn = '0;
    logic [2:0]  dst_sel, srca_sel, srcb_sel;
    logic [4:0]  alu_op;
    logic [15:0] imm_word;
    logic        wb_en;

    int checks = 0;
    int errors = 0;

    // model state
    logic [2:0]  m_dst = 0, m_sa = 0, m_sb = 0;
    logic [4:0]  m_op = 0;
    logic [15:0] m_imm = 0;
    logic        m_wb = 0;

    always #10 clk = ~clk;

    insn_field_decoder dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic wb_of(input logic [3:0] o);
        return !(o == 4'd7 || o == 4'd12 || o == 4'd13);
    endfunction

    // apply one cycle, update model, compare after the edge
    task automatic step(input logic r, input logic a, input logic [15:0] w, input string req);
        @(negedge clk);
        rst_n = r; advance = a; insn = w;
        @(posedge clk);
        if (!r) begin
            m_dst = 0; m_sa = 0; m_sb = 0; m_op = 0; m_imm = 0; m_wb = 0;
        end else if (a) begin
            m_dst = w[11:9]; m_sa = w[7:5]; m_sb = w[4:2];
            m_op = {w[15:12], w[8]}; m_imm = {w[7:0], w[7:0]};
            m_wb = wb_of(w[15:12]);
        end
        #1;
        chk({req, " dst"},  dst_sel,  m_dst);
        chk({req, " srca"}, srca_sel, m_sa);
        chk({req, " srcb"}, srcb_sel, m_sb);
        chk({req, " op"},   alu_op,   m_op);
        chk({req, " imm"},  imm_word, m_imm);
        chk({req, " wb"},   wb_en,    m_wb);
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state, including after a loaded value
        step(1'b0, 1'b1, 16'hFFFF, "R1");
        step(1'b1, 1'b1, 16'h8FFF, "R2");
        step(1'b0, 1'b0, 16'h1234, "R1");
        // R5 all opcodes, R7 both mode bits and spare bits
        for (int o = 0; o < 16; o++) begin
            step(1'b1, 1'b1, {o[3:0], 3'd5, 1'b0, 3'd2, 3'd6, 2'b00}, "R5");
            step(1'b1, 1'b1, {o[3:0], 3'd5, 1'b1, 3'd2, 3'd6, 2'b11}, "R7");
        end
        // R2 every register number in each select
        for (int r = 0; r < 8; r++)
            step(1'b1, 1'b1, {4'h0, r[2:0], 1'b0, r[2:0], ~r[2:0], 2'b01}, "R2");
        // R3/R4 random words
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'b1, 16'($urandom), "R3 R4");
        // R6 hold while advance low and insn changes
        step(1'b1, 1'b1, 16'hC2A5, "R6");
        for (int i = 0; i < 40; i++)
            step(1'b1, 1'b0, 16'($urandom), "R6");
        // mixed
        for (int i = 0; i < 300; i++)
            step(1'b1, 1'($urandom), 16'($urandom), "R6 mix");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule